// File: doc/BRIEF.md
# Sink-Phase Resampling Core

This block sits at the heart of an asynchronous sample rate converter, downstream of a first-stage oversampling filter. It keeps a running sink phase on a dense source grid. That grid has 2^17 points per source sample period: 512 oversampled points, each split into 256 interpolation steps. Each sink-sample strobe adds a measured rate word to the phase. The rate word equals the grid size times the source-to-sink rate ratio and may drift slowly. The sum wraps modulo the grid size.

The integer part of the phase names which pair of neighbouring oversampled samples the block wants. The upstream oversampler returns that pair on two sample inputs. At the next strobe the block forms a linear interpolation between them, weighted by the fractional grid bits. It registers the result, holds it until the next strobe, and flags it with a one-cycle valid pulse. The rate word carries extra fraction bits below the grid, so truncation error in the rate does not pile up in the phase.

Top module: `srp_resample_core`

## Requirements
- R1: While rst_n is low at a clock edge, the phase is cleared, so after that edge samp_idx is 0, out_smp is 0 and out_vld is 0.
- R2: The phase is ACC_W = 25 bits wide. At each clock edge where sink_stb is high, the rate word is added to it. samp_idx always shows phase bits [24:16], which are the oversampled-sample index.
- R3: The phase wraps modulo 2^25 (2^17 grid points with 8 rate-fraction bits). A carry out of bit 24 is dropped, so a rate word of 0x1FFFF00 moves the phase back by one grid step.
- R4: With sink_stb low, the phase, samp_idx and out_smp keep their values.
- R5: At a strobe, out_smp is loaded with lo + floor((hi − lo) × w / 256). Here lo and hi are the signed two's-complement values on samp_lo and samp_hi, and w is phase bits [15:8] before that strobe's update. The result is visible one cycle after the strobe.
- R6: out_vld is high for exactly the cycle after each strobe and low otherwise.
- R7: Rate-word bits [7:0] accumulate below the grid. Two strobes of 0x80 each carry one unit into w.
- R8: A new rate word takes effect from the first strobe that presents it, so the phase step follows a slowly varying rate.
- R9: The rounding is toward negative infinity for descending and negative-valued pairs, and a weight of 0 returns lo exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sink_stb | input | 1 | One-cycle sink sample strobe |
| ratio_word | input | ACC_W (25) | Phase step: 17 grid bits above 8 fraction bits |
| samp_lo | input | DATA_W (24) | Oversampled sample at the requested index (signed) |
| samp_hi | input | DATA_W (24) | Following oversampled sample (signed) |
| samp_idx | output | IDX_W (9) | Requested oversampled-sample index |
| out_smp | output | DATA_W (24) | Interpolated output sample (signed), held between strobes |
| out_vld | output | 1 | Pulses the cycle after each strobe |

## Verification
Four properties are checked on every cycle:
- the valid pulse follows each strobe and never appears on its own;
- the index and the output stay frozen between strobes;
- each strobe moves the index by the grid part of the rate word, plus at most one carry;
- every output lies inside the span of the two samples it came from.

The exact interpolated value needs scenarios in the bench. So do the floor rounding on negative slopes, the build-up of sub-grid rate fraction into the weight, and wrap-around at the top of the grid. The bench covers these with its own reference model of the phase.

// File: rtl/srp_pkg.sv
// Package: srp_pkg
// Shared width defaults for the sink-phase resampling core.
// Assumes the grid is a power of two, so the modulo wrap is a plain
// truncation of the accumulator.
package srp_pkg;
    localparam int SRP_IDX_W   = 9;   // oversampled points per source period, log2
    localparam int SRP_WGT_W   = 8;   // interpolation steps per oversampled point, log2
    localparam int SRP_RFRAC_W = 8;   // rate-word bits below the grid
    localparam int SRP_DATA_W  = 24;  // sample width, signed
endpackage

// File: rtl/srp_phase_acc.sv
// Module: srp_phase_acc
// Sink phase accumulator. It adds the step word on each enable and wraps
// modulo 2^ACC_W. It presents the index field and the weight field.
// Assumes ACC_W = IDX_W + WGT_W + RFRAC_W.
module srp_phase_acc #(
    parameter int IDX_W   = 9,
    parameter int WGT_W   = 8,
    parameter int RFRAC_W = 8,
    parameter int ACC_W   = IDX_W + WGT_W + RFRAC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_en,
    input  logic [ACC_W-1:0] step_word,
    output logic [IDX_W-1:0] idx,
    output logic [WGT_W-1:0] wgt
);
    logic [ACC_W-1:0] phase_q;

    // Advance the phase on each strobe; the carry out drops, which gives the wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase_q <= '0;
        else if (step_en)
            phase_q <= phase_q + step_word;
    end

    // Split the phase into the index field and the weight field.
    always_comb begin
        idx = phase_q[ACC_W-1 -: IDX_W];
        wgt = phase_q[RFRAC_W +: WGT_W];
    end
endmodule

// File: rtl/srp_lerp.sv
// Module: srp_lerp
// Combinational linear interpolator: y = a + floor((b - a) * w / 2^WGT_W).
// Assumes signed two's-complement samples. The result always lies between
// a and b, so it fits in DATA_W bits.
module srp_lerp #(
    parameter int DATA_W = 24,
    parameter int WGT_W  = 8
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic [WGT_W-1:0]  w,
    output logic [DATA_W-1:0] y
);
    localparam int DIFF_W = DATA_W + 1;
    localparam int PROD_W = DIFF_W + WGT_W + 1;

    logic signed [DIFF_W-1:0] diff;
    logic signed [PROD_W-1:0] prod;
    logic signed [PROD_W-1:0] a_ext;
    logic signed [PROD_W-1:0] sum_full;

    // Form the slope, scale it by the weight, floor-shift it, and add the base.
    always_comb begin
        diff     = $signed({b[DATA_W-1], b}) - $signed({a[DATA_W-1], a});
        prod     = diff * $signed({1'b0, w});
        a_ext    = $signed({{(PROD_W-DATA_W){a[DATA_W-1]}}, a});
        sum_full = a_ext + (prod >>> WGT_W);
        y        = DATA_W'(sum_full);
    end
endmodule

// File: rtl/srp_out_stage.sv
// Module: srp_out_stage
// Output register. It captures the interpolated value on a load strobe,
// holds it otherwise, and raises valid for one cycle per load.
module srp_out_stage #(
    parameter int DATA_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] d,
    output logic [DATA_W-1:0] q,
    output logic              vld
);
    // Capture on a strobe, flag one cycle later, and hold between strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q   <= '0;
            vld <= 1'b0;
        end else begin
            vld <= load;
            if (load)
                q <= d;
        end
    end
endmodule

// File: rtl/srp_resample_core.sv
// Module: srp_resample_core
// Resampling core. It keeps a modulo-2^17-grid sink phase that advances by
// ratio_word on each sink strobe, and requests the oversampled sample pair
// at the phase index. On each strobe it registers the linear interpolation
// of that pair, weighted by the fraction before the update.
// Assumes the upstream oversampler presents the pair for samp_idx on
// samp_lo/samp_hi by the next strobe.
module srp_resample_core
    import srp_pkg::*;
#(
    parameter int IDX_W   = SRP_IDX_W,
    parameter int WGT_W   = SRP_WGT_W,
    parameter int RFRAC_W = SRP_RFRAC_W,
    parameter int DATA_W  = SRP_DATA_W,
    parameter int ACC_W   = IDX_W + WGT_W + RFRAC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sink_stb,
    input  logic [ACC_W-1:0]  ratio_word,
    input  logic [DATA_W-1:0] samp_lo,
    input  logic [DATA_W-1:0] samp_hi,
    output logic [IDX_W-1:0]  samp_idx,
    output logic [DATA_W-1:0] out_smp,
    output logic              out_vld
);
    logic [WGT_W-1:0]  cur_wgt;
    logic [DATA_W-1:0] lerp_y;

    srp_phase_acc #(
        .IDX_W(IDX_W), .WGT_W(WGT_W), .RFRAC_W(RFRAC_W), .ACC_W(ACC_W)
    ) u_phase (
        .clk(clk), .rst_n(rst_n), .step_en(sink_stb),
        .step_word(ratio_word), .idx(samp_idx), .wgt(cur_wgt)
    );

    srp_lerp #(.DATA_W(DATA_W), .WGT_W(WGT_W)) u_lerp (
        .a(samp_lo), .b(samp_hi), .w(cur_wgt), .y(lerp_y)
    );

    srp_out_stage #(.DATA_W(DATA_W)) u_out (
        .clk(clk), .rst_n(rst_n), .load(sink_stb),
        .d(lerp_y), .q(out_smp), .vld(out_vld)
    );
endmodule

// File: rtl/srp_resample_core_chk.sv
// Module: srp_resample_core_chk
// Port-level checker bound to srp_resample_core.
module srp_resample_core_chk #(
    parameter int IDX_W  = 9,
    parameter int DATA_W = 24,
    parameter int ACC_W  = 25
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sink_stb,
    input logic [ACC_W-1:0]  ratio_word,
    input logic [DATA_W-1:0] samp_lo,
    input logic [DATA_W-1:0] samp_hi,
    input logic [IDX_W-1:0]  samp_idx,
    input logic [DATA_W-1:0] out_smp,
    input logic              out_vld
);
    // R1: a reset edge clears the index, the output and the valid flag
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (samp_idx == '0 && out_smp == '0 && !out_vld));

    // R6: valid follows a strobe by one cycle, and only a strobe
    a_r6_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        sink_stb |=> out_vld);
    a_r6_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !sink_stb |=> !out_vld);

    // R4: without a strobe, the index and the output hold
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !sink_stb |=> ($stable(samp_idx) && $stable(out_smp)));

    // R2: the index moves by the grid part of the step, plus at most one carry
    a_r2_idx_advance: assert property (@(posedge clk) disable iff (!rst_n)
        sink_stb |=> ((IDX_W'(samp_idx - $past(samp_idx)
                        - $past(ratio_word[ACC_W-1 -: IDX_W]))) <= IDX_W'(1)));

    // R5: the output lies inside the span of the pair it was built from
    a_r5_in_span: assert property (@(posedge clk) disable iff (!rst_n)
        sink_stb |=>
        (($signed(out_smp) >= $signed($past(samp_lo)) &&
          $signed(out_smp) <= $signed($past(samp_hi))) ||
         ($signed(out_smp) <= $signed($past(samp_lo)) &&
          $signed(out_smp) >= $signed($past(samp_hi)))));
endmodule

bind srp_resample_core srp_resample_core_chk #(
    .IDX_W(IDX_W), .DATA_W(DATA_W), .ACC_W(ACC_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .sink_stb(sink_stb), .ratio_word(ratio_word),
    .samp_lo(samp_lo), .samp_hi(samp_hi), .samp_idx(samp_idx),
    .out_smp(out_smp), .out_vld(out_vld)
);

// File: tb/srp_resample_core_bench.sv
module srp_resample_core_bench;
    localparam int IDX_W  = 9;
    localparam int DATA_W = 24;
    localparam int ACC_W  = 25;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              sink_stb = 1'b0;
    logic [ACC_W-1:0]  ratio_word = '0;
    logic [DATA_W-1:0] samp_lo = '0;
    logic [DATA_W-1:0] samp_hi = '0;
    logic [IDX_W-1:0]  samp_idx;
    logic [DATA_W-1:0] out_smp;
    logic              out_vld;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct { longint val; string tag; } exp_t;
    exp_t sb_q[$];
    logic [ACC_W-1:0] model_ph = '0;

    always #10 clk = ~clk;

    srp_resample_core u_srp_resample_core (
        .clk(clk), .rst_n(rst_n), .sink_stb(sink_stb), .ratio_word(ratio_word),
        .samp_lo(samp_lo), .samp_hi(samp_hi), .samp_idx(samp_idx),
        .out_smp(out_smp), .out_vld(out_vld)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Driver: apply one strobe, check the requested index, queue the expected output
    task automatic strobe(input logic [ACC_W-1:0] rw, input longint lo, input longint hi, input string tag);
        longint w;
        exp_t e;
        @(negedge clk);
        check(samp_idx == model_ph[ACC_W-1 -: IDX_W], {tag, " R2 index"},
              samp_idx, model_ph[ACC_W-1 -: IDX_W]);
        w = longint'(model_ph[15:8]);
        e.val = lo + (((hi - lo) * w) >>> 8);
        e.tag = tag;
        sb_q.push_back(e);
        sink_stb   = 1'b1;
        ratio_word = rw;
        samp_lo    = lo[DATA_W-1:0];
        samp_hi    = hi[DATA_W-1:0];
        model_ph   = model_ph + rw;
        @(negedge clk);
        sink_stb = 1'b0;
    endtask

    // Monitor: compare each valid output with the head of the scoreboard
    always @(negedge clk) begin
        if (rst_n && out_vld) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R6 valid without strobe", 1, 0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check(longint'($signed(out_smp)) == e.val, {e.tag, " R5 value"},
                      longint'($signed(out_smp)), e.val);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [IDX_W-1:0]  held_idx;
        logic [DATA_W-1:0] held_out;
        logic [ACC_W-1:0]  rw;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(samp_idx == 0, "R1 index", samp_idx, 0);
        check(out_smp == 0, "R1 output", out_smp, 0);
        check(out_vld == 0, "R1 valid", out_vld, 0);
        rst_n = 1'b1;

        // R9: weight 0 returns lo exactly
        strobe(25'h0012380, 100, 356, "R9 zero weight");
        // R5: weight 0x23 on a rising pair (reads w as out)
        strobe(25'h0000000, 0, 256, "R5 weight read");
        // R9: negative slope, floor rounding
        strobe(25'h0000000, 100, -101, "R9 falling floor");
        strobe(25'h0000000, -5000, -4000, "R9 negative pair");

        // R4 / R6: idle, nothing moves and valid stays low
        @(negedge clk);
        held_idx = samp_idx;
        held_out = out_smp;
        repeat (6) @(negedge clk);
        check(samp_idx == held_idx, "R4 index hold", samp_idx, held_idx);
        check(out_smp == held_out, "R4 output hold", out_smp, held_out);
        check(out_vld == 0, "R6 idle valid", out_vld, 0);

        // R3: a step of 2^25 - 256 is one grid step backward; from a clean phase it wraps
        strobe(25'h1FFFFFF - model_ph + 25'd1, 0, 0, "R3 align to zero");
        strobe(25'h1FFFF00, 7, 7, "R3 wrap step");
        check(samp_idx == 9'h1FF, "R3 index after wrap", samp_idx, 9'h1FF);
        strobe(25'h0000100, 0, 256, "R3 weight 255");

        // R7: sub-grid fraction carries into the weight (phase now 0)
        strobe(25'h0000080, 0, 0, "R7 half");
        strobe(25'h0000080, 0, 0, "R7 half");
        strobe(25'h0000000, 0, 256, "R7 weight one");

        // R8: slowly varying rate around a 44.1k to 48k ratio
        for (int i = 0; i < 300; i++) begin
            rw = 25'h1D66666 + ACC_W'($urandom_range(0, 64)) - 25'd32;
            strobe(rw, longint'($signed(24'($urandom))), longint'($signed(24'($urandom))), "R8 drift");
            if (($urandom & 3) == 0) repeat (2) @(negedge clk);
        end

        repeat (3) @(negedge clk);
        check(sb_q.size() == 0, "R6 all strobes answered", sb_q.size(), 0);

        // R1: reset mid-run clears the phase again
        rst_n = 1'b0;
        @(negedge clk);
        check(samp_idx == 0 && out_vld == 0 && out_smp == 0, "R1 reset again", samp_idx, 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule